// File: doc/BRIEF.md
# Ring Melody Square-Wave Generator

This block drives a ringing buzzer with a square wave. One of eight fixed melody frequencies is selected by a 3-bit tone index. A control processor first stores the index with a load strobe. It then issues a start strobe, and the tone sounds from that edge on. A stop strobe does not cut the tone. The generator keeps sounding until the low half of the square period in progress is complete, so the buzzer never sees a truncated cycle.

Every frequency comes from one divider counter. The counter is reloaded with a half-period count that is computed at elaboration time from the reference clock frequency `REF_HZ`, as round(`REF_HZ` / (2·f)). A separate 2-bit volume code is held for the buzzer amplifier, from 00 (quietest) to 11 (loudest). While the generator is idle and the ring-detect input is high, an external melody input is passed straight to the buzzer. This lets software play tones outside the built-in set. A running internal tone always has precedence over that input.

Top module: `ring_melody_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes idle: `active` low, `buzz` low when `ring_det` is low, `level_out` = 00, stored tone index = 0.
- R2: Tone index 0..7 selects 822, 744, 1005, 909, 1187, 1074, 1451, 1312 Hz. Each half period lasts H = round(`REF_HZ`/(2·f)) clock cycles. `buzz` is high for the first half of every period and low for the second.
- R3: `tone_load` stores `tone_sel` at the clock edge. Only the next accepted start uses the stored index. If a load and a start arrive at the same edge, the start uses the index that was stored before that edge. A load during ringing does not change the running tone.
- R4: When idle, `ring_start` sets `active` at that edge and begins a new period with `buzz` high.
- R5: `ring_start` while `active` is high has no effect on the running tone or its timing.
- R6: After `ring_stop` is seen while active, `active` falls at the edge that completes the current low half-period. The active time is therefore a whole number of periods, 2·H cycles each, and `buzz` is low just before the end.
- R7: A `ring_stop` sampled at the very edge that completes a low half ends ringing at that edge. A stop one edge later rings one further full period.
- R8: `ring_stop` while idle is ignored and is not remembered for a later tone.
- R9: `level_load` copies `level_in` to `level_out` at the clock edge. At all other edges `level_out` holds, whether or not the block is ringing. 00 is the minimum level and 11 the maximum.
- R10: While idle with `ring_det` high, `buzz` follows `mel_in` combinationally. While active, `mel_in` has no effect on `buzz`.
- R11: While idle with `ring_det` low, `buzz` is low whatever `mel_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (frequency `REF_HZ`) |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_sel | input | 3 | Tone index to be stored |
| tone_load | input | 1 | Store strobe for `tone_sel` |
| ring_start | input | 1 | Ring start strobe |
| ring_stop | input | 1 | Stop request strobe |
| level_in | input | 2 | Volume code to be stored |
| level_load | input | 1 | Store strobe for `level_in` |
| mel_in | input | 1 | External melody input |
| ring_det | input | 1 | Ring supply present |
| buzz | output | 1 | Buzzer square wave |
| level_out | output | 2 | Held volume code |
| active | output | 1 | Internal tone running |

## Verification
Two events can meet at one clock edge: a stop request, and the edge that completes a low half-period. The bench provokes this by timing the stop strobe from the start edge at exactly two half-periods, and again one edge later. The first case must end ringing on that edge. The second must ring one further full period. A tone load and a start strobe at the same edge, and a start or stop strobe while ringing, are also compared cycle by cycle against a behavioural model.

// File: rtl/rmg_pkg.sv
// Package: melody frequency table and divider count arithmetic.
// Assumes the reference clock is far faster than the highest tone.
package rmg_pkg;

    localparam int unsigned NUM_TONES = 8;

    // Frequency in Hz of each tone index.
    function automatic int unsigned tone_hz(input int unsigned idx);
        case (idx)
            0:       tone_hz = 822;
            1:       tone_hz = 744;
            2:       tone_hz = 1005;
            3:       tone_hz = 909;
            4:       tone_hz = 1187;
            5:       tone_hz = 1074;
            6:       tone_hz = 1451;
            default: tone_hz = 1312;
        endcase
    endfunction

    // Rounded half-period length in reference cycles.
    function automatic int unsigned half_count(input int unsigned ref_hz,
                                               input int unsigned idx);
        int unsigned f;
        f = tone_hz(idx);
        half_count = (ref_hz + f) / (2 * f);
    endfunction

endpackage

// File: rtl/rmg_divider.sv
// Square-wave divider: counts one half period, then flips the phase.
// Assumes half_len >= 2. A restart forces the high phase and clears the count.
// period_end marks the edge that completes the low half.
module rmg_divider #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic [CW-1:0] half_len,
    output logic          phase,
    output logic          period_end
);
    logic [CW-1:0] cnt;
    logic          half_done;

    // Last cycle of the current half period.
    assign half_done  = (cnt == half_len - CW'(1));
    assign period_end = run && !phase && half_done;

    // Half-period counter and phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (restart) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else if (run) begin
            if (half_done) begin
                cnt   <= '0;
                phase <= ~phase;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/rmg_ctrl.sv
// Ring sequencer: accepts a start only when idle, latches the tone in use,
// and defers a stop request to the next period end.
module rmg_ctrl #(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ring_start,
    input  logic          ring_stop,
    input  logic [IW-1:0] stored_idx,
    input  logic          period_end,
    output logic          restart,
    output logic          active,
    output logic [IW-1:0] run_idx
);
    logic stop_pend;
    logic stop_now;

    assign restart  = !active && ring_start;
    assign stop_now = ring_stop || stop_pend;

    // Running flag: set by an accepted start, cleared at a period end under stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (restart)
            active <= 1'b1;
        else if (active && period_end && stop_now)
            active <= 1'b0;
    end

    // Pending stop: remembered only while ringing.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            stop_pend <= 1'b0;
        else if (period_end && stop_now)
            stop_pend <= 1'b0;
        else if (ring_stop)
            stop_pend <= 1'b1;
    end

    // Tone in use, captured on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_idx <= '0;
        else if (restart)
            run_idx <= stored_idx;
    end
endmodule

// File: rtl/ring_melody_gen.sv
// Ring melody generator top: stores the tone index and the volume code,
// runs the divider for the selected tone, and muxes the external melody
// onto the buzzer while idle and ring_det is high.
// Assumes all strobes are synchronous to clk.
module ring_melody_gen #(
    parameter int unsigned REF_HZ = 1790000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] tone_sel,
    input  logic       tone_load,
    input  logic       ring_start,
    input  logic       ring_stop,
    input  logic [1:0] level_in,
    input  logic       level_load,
    input  logic       mel_in,
    input  logic       ring_det,
    output logic       buzz,
    output logic [1:0] level_out,
    output logic       active
);
    import rmg_pkg::*;

    localparam int IW = $clog2(NUM_TONES);
    localparam int CW = $clog2(REF_HZ / 1000 + 2);

    logic [IW-1:0] stored_idx;
    logic [IW-1:0] run_idx;
    logic [CW-1:0] half_tab [NUM_TONES];
    logic          restart;
    logic          phase;
    logic          period_end;

    // Half-period count for each tone, fixed at elaboration.
    for (genvar g = 0; g < NUM_TONES; g++) begin : g_tab
        localparam int unsigned HC = half_count(REF_HZ, g);
        assign half_tab[g] = CW'(HC);
    end

    // Stored tone index for the next start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stored_idx <= '0;
        else if (tone_load)
            stored_idx <= tone_sel;
    end

    // Held volume code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_out <= 2'b00;
        else if (level_load)
            level_out <= level_in;
    end

    rmg_ctrl #(.IW(IW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_start (ring_start),
        .ring_stop  (ring_stop),
        .stored_idx (stored_idx),
        .period_end (period_end),
        .restart    (restart),
        .active     (active),
        .run_idx    (run_idx)
    );

    rmg_divider #(.CW(CW)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .run        (active),
        .half_len   (half_tab[run_idx]),
        .phase      (phase),
        .period_end (period_end)
    );

    // Buzzer source: the internal tone has precedence, else the external melody.
    always_comb begin
        if (active)
            buzz = phase;
        else
            buzz = ring_det && mel_in;
    end
endmodule

// File: rtl/rmg_checker.sv
// Checker for ring_melody_gen: port-level timing properties.
module rmg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ring_start,
    input logic       level_load,
    input logic [1:0] level_in,
    input logic       mel_in,
    input logic       ring_det,
    input logic       buzz,
    input logic [1:0] level_out,
    input logic       active
);
    assert_idle_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !ring_det) |-> !buzz);

    assert_melody_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && ring_det) |-> (buzz == mel_in));

    assert_start_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && ring_start) |=> (active && buzz));

    assert_stay_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !ring_start) |=> !active);

    assert_end_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> !$past(buzz));

    assert_level_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        level_load |=> (level_out == $past(level_in)));

    assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !level_load |=> $stable(level_out));
endmodule

bind ring_melody_gen rmg_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_start (ring_start),
    .level_load (level_load),
    .level_in   (level_in),
    .mel_in     (mel_in),
    .ring_det   (ring_det),
    .buzz       (buzz),
    .level_out  (level_out),
    .active     (active)
);

// File: tb/ring_melody_gen_tb.sv
module ring_melody_gen_tb;
    localparam int unsigned REF = 1790000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] tone_sel = '0;
    logic       tone_load = 1'b0;
    logic       ring_start = 1'b0;
    logic       ring_stop = 1'b0;
    logic [1:0] level_in = '0;
    logic       level_load = 1'b0;
    logic       mel_in = 1'b0;
    logic       ring_det = 1'b0;
    logic       buzz;
    logic [1:0] level_out;
    logic       active;

    int checks = 0;
    int errors = 0;
    bit chk_en = 0;

    // Behavioural model state
    int m_active = 0, m_phase = 0, m_cnt = 0, m_pend = 0;
    int m_sel = 0, m_stored = 0, m_lvl = 0;

    always #10 clk = ~clk;

    ring_melody_gen #(.REF_HZ(REF)) u_dut (.*);

    function automatic int hz(input int i);
        int t [8] = '{822, 744, 1005, 909, 1187, 1074, 1451, 1312};
        return t[i];
    endfunction

    function automatic int half(input int i);
        return $rtoi(REF / (2.0 * hz(i)) + 0.5);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced at every rising edge
    always @(posedge clk) begin
        int old_stored;
        int stop_now;
        old_stored = m_stored;
        if (!rst_n) begin
            m_active = 0; m_phase = 0; m_cnt = 0; m_pend = 0;
            m_sel = 0; m_stored = 0; m_lvl = 0;
        end else begin
            if (tone_load) m_stored = int'(tone_sel);
            if (level_load) m_lvl = int'(level_in);
            if (m_active == 0) begin
                if (ring_start) begin
                    m_active = 1; m_phase = 1; m_cnt = 0; m_pend = 0;
                    m_sel = old_stored;
                end
            end else begin
                stop_now = (ring_stop || m_pend != 0) ? 1 : 0;
                if (m_cnt == half(m_sel) - 1) begin
                    m_cnt = 0;
                    if (m_phase == 1) m_phase = 0;
                    else if (stop_now == 1) begin m_active = 0; m_pend = 0; end
                    else m_phase = 1;
                end else begin
                    m_cnt++;
                end
                if (m_active == 1 && ring_stop) m_pend = 1;
                if (m_active == 1 && stop_now == 1 && m_phase == 1 && m_cnt == 0) m_pend = 0;
            end
        end
    end

    // Cycle comparison, between edges
    always @(negedge clk) begin
        #5;
        if (chk_en) begin
            int eb;
            eb = (m_active != 0) ? m_phase : int'(ring_det && mel_in);
            check((m_active != 0) ? "R2 buzz" : (ring_det ? "R10 buzz" : "R11 buzz"),
                  int'(buzz), eb);
            check("R6 active", int'(active), m_active);
            check("R9 level", int'(level_out), m_lvl);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Run one tone; stop strobe at t=stop_t; R3/R5/R9/R10 stimulus during ringing
    task automatic run_tone(input int idx, input int stop_t, input int exp_act, input string tag);
        int t, act_cnt, high_cnt;
        @(negedge clk);
        tone_sel = 3'(idx); tone_load = 1;
        @(negedge clk);
        tone_load = 0; ring_start = 1;
        @(negedge clk);
        ring_start = 0;
        ring_det = 1;
        t = 1; act_cnt = 0; high_cnt = 0;
        while (active && t < 10 * half(idx)) begin
            act_cnt += int'(active);
            high_cnt += int'(buzz);
            mel_in = t[0];                                  // R10: ignored while active
            ring_stop  = (t == stop_t);
            tone_load  = (t == 5);                          // R3: load while ringing
            tone_sel   = (t == 5) ? ~3'(idx) : 3'(idx);
            ring_start = (t == 7);                          // R5: start while ringing
            level_load = (t == 9);                          // R9
            level_in   = 2'(idx);
            @(negedge clk);
            t++;
        end
        ring_stop = 0; ring_start = 0; tone_load = 0; level_load = 0; mel_in = 0;
        check({tag, " active cycles"}, act_cnt, exp_act);
        check("R2 high cycles", high_cnt, exp_act / 2);
    endtask

    initial begin
        tick(4);
        rst_n = 1;
        chk_en = 1;
        #6;
        check("R1 active", int'(active), 0);
        check("R1 buzz", int'(buzz), 0);
        check("R1 level", int'(level_out), 0);
        // R9: level codes, minimum and maximum
        @(negedge clk); level_in = 2'b11; level_load = 1;
        @(negedge clk); level_load = 0; level_in = 2'b01; #6;
        check("R9 max", int'(level_out), 3);
        @(negedge clk); level_load = 1;
        @(negedge clk); level_load = 0; level_in = 2'b00; #6;
        check("R9 load", int'(level_out), 1);
        // R10/R11: external melody while idle
        @(negedge clk); ring_det = 1; mel_in = 1; #6;
        check("R10 pass high", int'(buzz), 1);
        @(negedge clk); mel_in = 0; #6;
        check("R10 pass low", int'(buzz), 0);
        @(negedge clk); ring_det = 0; mel_in = 1; #6;
        check("R11 blocked", int'(buzz), 0);
        @(negedge clk); mel_in = 0;
        // R1: first start after reset uses index 0
        @(negedge clk); ring_start = 1;
        @(negedge clk); ring_start = 0;
        begin
            int w = 0;
            while (buzz && w < 5000) begin w++; @(negedge clk); end
            check("R1 stored index 0 half", w, half(0));
        end
        ring_stop = 1; @(negedge clk); ring_stop = 0;
        while (active) @(negedge clk);
        // R2/R6: every tone, stop in low or high half
        for (int i = 0; i < 8; i++)
            run_tone(i, (i % 2 == 0) ? half(i) + 3 : 3, 2 * half(i), "R6");
        // R7: stop on the period-end edge, and one edge later
        run_tone(7, 2 * half(7), 2 * half(7), "R7 coincide");
        run_tone(7, 2 * half(7) + 1, 4 * half(7), "R7 late");
        // R8: stop while idle is not remembered
        @(negedge clk); ring_stop = 1;
        @(negedge clk); ring_stop = 0;
        run_tone(0, 3 * half(0) + 2, 4 * half(0), "R8");
        // R3: load and start at the same edge uses the earlier index
        @(negedge clk); tone_sel = 3'd6; tone_load = 1;
        @(negedge clk); tone_sel = 3'd1; ring_start = 1;
        @(negedge clk); tone_load = 0; ring_start = 0;
        begin
            int w = 1;
            @(negedge clk);
            while (buzz && w < 5000) begin w++; @(negedge clk); end
            check("R3 same-edge index", w, half(6));
        end
        ring_stop = 1; @(negedge clk); ring_stop = 0;
        while (active) @(negedge clk);
        tick(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule